// File: doc/BRIEF.md
# Bipolar Pulse Telegram Validity Checker

This block judges whether one received telegram on a two-wire bus is well formed. Upstream logic turns the line signal into per-cycle events. A pulse strobe carries a polarity flag. A data-bit strobe carries the decoded bit value. Two markers open and close the frame, and a flag is high while the bus is in one of its silent pause windows. The checker watches these events from the opening marker to the closing marker. It applies six rejection rules at the same time and keeps only the first rule that fails. One clock after the closing marker it reports either a good result or a single error code.

The decoded bits are shifted into a data register that is returned with the verdict. Downstream logic can use the payload of a good telegram without decoding it again. The register is as wide as the longer of the two telegram lengths: 14 bit times for a request and 7 for a response. A count of received bits comes with the data, so the consumer can tell which of the two lengths arrived. A pulse seen in a pause window while no frame is open is charged against the next telegram. This is the pause that precedes that telegram.

Top module: `telegram_checker`

## Requirements
- R1: While reset is low and in the cycle after it, res_stb, res_ok, res_err, res_data and res_nbits are all zero.
- R2: A closing marker that arrives while a frame is open, with no opening marker in the same cycle, raises res_stb for exactly one cycle, on the next clock. res_ok, res_err, res_data and res_nbits take their new values in that same cycle and hold them until the next result.
- R3: If the first pulse of the frame is positive (polarity input 1), res_err bit 0 flags it.
- R4: If a pulse has the same polarity as the pulse before it in the same frame, res_err bit 1 flags it.
- R5: If GAP_MAX consecutive in-frame cycles carry no pulse, res_err bit 2 flags it. The count starts after the opening marker or after the latest pulse, and includes the closing-marker cycle. A run of GAP_MAX-1 such cycles is accepted.
- R6: If an odd number of the decoded bits in the frame are 1, res_err bit 3 flags it.
- R7: If the frame ends with no pulse, or with a last pulse that is negative, res_err bit 4 flags it.
- R8: res_err bit 5 flags a frame when a pulse arrives while the pause flag is high. This applies inside the frame, and also while no frame is open before the frame's opening marker.
- R9: res_err has at most one bit set. It names the rule that failed earliest in the frame; a pause pulse seen before the opening marker counts as the earliest. When several rules fail in the same cycle, the lowest bit index wins. res_ok is 1 exactly when res_err is zero.
- R10: Each in-frame bit strobe shifts its value into bit 0 of res_data, so the first bit ends in the highest position. res_data keeps the last DATA_W bits. res_nbits counts the strobes and saturates at its all-ones value (31 by default).
- R11: An opening marker while a frame is open throws the old frame away and starts again. A closing marker while no frame is open produces no result and leaves the outputs unchanged. Pulses and bits outside a frame are ignored, except for the pause rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | Opening marker, one cycle |
| frm_end | input | 1 | Closing marker, one cycle; the strobes in this cycle belong to the frame |
| pulse_stb | input | 1 | A line pulse was detected this cycle |
| pulse_pos | input | 1 | Polarity of the pulse: 1 positive, 0 negative |
| bit_stb | input | 1 | A decoded information bit is valid this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| pause_win | input | 1 | High while the bus is inside a master or slave pause |
| res_stb | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Telegram valid |
| res_err | output | 6 | One-hot first error: 0 start, 1 alternation, 2 gap, 3 parity, 4 end, 5 pause |
| res_data | output | DATA_W (14) | Decoded bits, last received in bit 0 |
| res_nbits | output | CNT_W (5) | Number of bit strobes in the frame, saturating |

## Verification
The assertions check on every cycle that each result strobe follows an accepted closing marker and lasts one cycle, that the error code is one-hot or empty and agrees with res_ok, and that an error already latched inside a frame is never replaced. Which rule a given stimulus trips, the exact gap boundary, how ties between rules in one cycle are resolved, that a pause pulse is charged to the following frame, the order of bits in the data register, and the restart and stray-marker cases can only be shown by the bench scenarios. The bench compares those against its own frame model.

// File: rtl/tgc_pkg.sv
// Shared definitions for the telegram checker: rule indices and the
// error vector type. Assumes exactly six rejection rules.
package tgc_pkg;
    localparam int unsigned ERR_N = 6;

    typedef logic [ERR_N-1:0] err_vec_t;

    // Bit index of each rule inside the error vector; lower index wins ties.
    typedef enum int unsigned {
        E_START = 0,
        E_ALT   = 1,
        E_GAP   = 2,
        E_PAR   = 3,
        E_END   = 4,
        E_PAUSE = 5
    } err_idx_e;

    // Keep only the lowest set bit of a violation vector.
    function automatic err_vec_t lowest_err(input err_vec_t v);
        return v & (~v + err_vec_t'(1));
    endfunction
endpackage

// File: rtl/tgc_pulse_rules.sv
// Polarity rules for one telegram: the first pulse must be negative,
// pulses must alternate, and a pulse inside a pause window is an error.
// Also gives the next-cycle view of "any pulse seen" and "last polarity"
// so the end rule can include a pulse in the closing cycle. A pause pulse
// seen while no frame is open is held as pending until the next frame opens.
// Assumes clear (opening marker) takes priority over all other updates.
module tgc_pulse_rules (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic pulse_stb,
    input  logic pulse_pos,
    input  logic pause_win,
    output logic viol_start,
    output logic viol_alt,
    output logic viol_pause,
    output logic pause_pend,
    output logic seen_nx,
    output logic last_pos_nx
);
    logic seen_q;
    logic last_q;
    logic pend_q;
    logic take;

    // Qualify a pulse as belonging to the open frame.
    always_comb begin
        take = active & pulse_stb;
    end

    // Per-cycle rule violations and next-state view for the end check.
    always_comb begin
        viol_start  = take & ~seen_q & pulse_pos;
        viol_alt    = take & seen_q & (pulse_pos == last_q);
        viol_pause  = take & pause_win;
        seen_nx     = seen_q | take;
        last_pos_nx = take ? pulse_pos : last_q;
        pause_pend  = pend_q;
    end

    // Track the pulse history of the frame and any pending pause pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (clear) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (take) begin
                seen_q <= 1'b1;
                last_q <= pulse_pos;
            end
            if (!active && pulse_stb && pause_win) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tgc_gap_timer.sv
// Counts pulse-free in-frame cycles and flags the cycle in which the run
// reaches GAP_MAX. The counter saturates at GAP_MAX-1, so the flag stays
// up for every further silent cycle. Assumes GAP_MAX >= 2.
module tgc_gap_timer #(
    parameter int unsigned GAP_MAX = 16,
    localparam int unsigned CW = $clog2(GAP_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic pulse_stb,
    output logic timeout
);
    localparam logic [CW-1:0] LIM = CW'(GAP_MAX - 1);

    logic [CW-1:0] cnt_q;

    // Flag a silent cycle that would make the run GAP_MAX long.
    always_comb begin
        timeout = active & ~pulse_stb & (cnt_q == LIM);
    end

    // Restart on a pulse or a new frame, otherwise count silent cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (active) begin
            if (pulse_stb) begin
                cnt_q <= '0;
            end else if (cnt_q != LIM) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tgc_bit_collect.sv
// Shifts the decoded bits of a frame into a register, counts them with
// saturation and keeps their running parity. The next-state outputs let
// the top include a bit strobe in the closing cycle. Assumes DATA_W >= 2.
module tgc_bit_collect #(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [DATA_W-1:0] data_nx,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic              odd_nx
);
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              odd_q;

    // Next register contents when a bit is accepted this cycle.
    always_comb begin
        data_nx = data_q;
        cnt_nx  = cnt_q;
        odd_nx  = odd_q;
        if (active && bit_stb) begin
            data_nx = {data_q[DATA_W-2:0], bit_val};
            odd_nx  = odd_q ^ bit_val;
            if (cnt_q != '1) begin
                cnt_nx = cnt_q + 1'b1;
            end
        end
    end

    // Hold the collected bits; a new frame empties them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data_q <= '0;
            cnt_q  <= '0;
            odd_q  <= 1'b0;
        end else begin
            data_q <= data_nx;
            cnt_q  <= cnt_nx;
            odd_q  <= odd_nx;
        end
    end
endmodule

// File: rtl/telegram_checker.sv
// Validity checker for one bipolar-pulse telegram. It combines the pulse
// rules, the gap timer and the bit collector, keeps the first error of the
// frame, and issues a one-cycle result one clock after an accepted closing
// marker. Assumes markers and strobes are single-cycle and synchronous.
module telegram_checker #(
    parameter int unsigned GAP_MAX  = 16,
    parameter int unsigned REQ_BITS = 14,
    parameter int unsigned RSP_BITS = 7,
    localparam int unsigned DATA_W  = (REQ_BITS > RSP_BITS) ? REQ_BITS : RSP_BITS,
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              pulse_stb,
    input  logic              pulse_pos,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              pause_win,
    output logic              res_stb,
    output logic              res_ok,
    output logic [5:0]        res_err,
    output logic [DATA_W-1:0] res_data,
    output logic [CNT_W-1:0]  res_nbits
);
    import tgc_pkg::*;

    logic              in_frame_q;
    err_vec_t          err_q;
    err_vec_t          viol;
    err_vec_t          err_nx;
    logic              end_ok;
    logic              v_start, v_alt, v_pause, pend, seen_nx, last_nx;
    logic              v_gap;
    logic [DATA_W-1:0] data_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic              odd_nx;

    tgc_pulse_rules u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (frm_start),
        .active     (in_frame_q),
        .pulse_stb  (pulse_stb),
        .pulse_pos  (pulse_pos),
        .pause_win  (pause_win),
        .viol_start (v_start),
        .viol_alt   (v_alt),
        .viol_pause (v_pause),
        .pause_pend (pend),
        .seen_nx    (seen_nx),
        .last_pos_nx(last_nx)
    );

    tgc_gap_timer #(.GAP_MAX(GAP_MAX)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frm_start),
        .active   (in_frame_q),
        .pulse_stb(pulse_stb),
        .timeout  (v_gap)
    );

    tgc_bit_collect #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (frm_start),
        .active (in_frame_q),
        .bit_stb(bit_stb),
        .bit_val(bit_val),
        .data_nx(data_nx),
        .cnt_nx (cnt_nx),
        .odd_nx (odd_nx)
    );

    // Accept a closing marker only for an open frame that is not restarting.
    always_comb begin
        end_ok = in_frame_q & frm_end & ~frm_start;
    end

    // Gather this cycle's violations and resolve the first error.
    always_comb begin
        viol          = '0;
        viol[E_START] = v_start;
        viol[E_ALT]   = v_alt;
        viol[E_GAP]   = v_gap;
        viol[E_PAR]   = end_ok & odd_nx;
        viol[E_END]   = end_ok & (~seen_nx | ~last_nx);
        viol[E_PAUSE] = v_pause;
        err_nx        = (err_q != '0) ? err_q : lowest_err(viol);
    end

    // Frame state and the latched first error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            err_q      <= '0;
        end else if (frm_start) begin
            in_frame_q <= 1'b1;
            err_q      <= pend ? err_vec_t'(1 << E_PAUSE) : '0;
        end else if (in_frame_q) begin
            err_q <= err_nx;
            if (frm_end) begin
                in_frame_q <= 1'b0;
            end
        end
    end

    // Result registers: strobe for one cycle, hold values until the next result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_stb   <= 1'b0;
            res_ok    <= 1'b0;
            res_err   <= '0;
            res_data  <= '0;
            res_nbits <= '0;
        end else begin
            res_stb <= end_ok;
            if (end_ok) begin
                res_err   <= err_nx;
                res_ok    <= (err_nx == '0);
                res_data  <= data_nx;
                res_nbits <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/tgc_checker.sv
// Protocol checker for telegram_checker, attached by bind. Assumes the
// six-bit one-hot error encoding of tgc_pkg.
module tgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_start,
    input logic       frm_end,
    input logic       in_frame_q,
    input logic [5:0] err_q,
    input logic       res_stb,
    input logic       res_ok,
    input logic [5:0] res_err
);
    assert_strobe_follows_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |-> $past(frm_end && !frm_start && in_frame_q));

    assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |=> !res_stb);

    assert_err_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |-> $onehot0(res_err));

    assert_ok_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |-> (res_ok == (res_err == 6'd0)));

    assert_first_err_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_q && !frm_start && (err_q != 6'd0)) |=> (err_q == $past(err_q)));
endmodule

bind telegram_checker tgc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .in_frame_q(in_frame_q),
    .err_q     (err_q),
    .res_stb   (res_stb),
    .res_ok    (res_ok),
    .res_err   (res_err)
);

// File: tb/sim_telegram_checker.sv
module sim_telegram_checker;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 16;
    localparam int DW = 14;
    localparam int CW = 5;
    localparam int MAXC = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 0, frm_end = 0, pulse_stb = 0, pulse_pos = 0;
    logic bit_stb = 0, bit_val = 0, pause_win = 0;
    logic          res_stb, res_ok;
    logic [5:0]    res_err;
    logic [DW-1:0] res_data;
    logic [CW-1:0] res_nbits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit ap[MAXC], apos[MAXC], ab[MAXC], av[MAXC], apz[MAXC];
    int nlen;

    always #(CLK_PERIOD/2) clk = ~clk;

    telegram_checker #(.GAP_MAX(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
        .pulse_stb(pulse_stb), .pulse_pos(pulse_pos), .bit_stb(bit_stb),
        .bit_val(bit_val), .pause_win(pause_win), .res_stb(res_stb),
        .res_ok(res_ok), .res_err(res_err), .res_data(res_data),
        .res_nbits(res_nbits)
    );

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_frame();
        for (int i = 0; i < MAXC; i++) begin
            ap[i] = 0; apos[i] = 0; ab[i] = 0; av[i] = 0; apz[i] = 0;
        end
        nlen = 0;
    endtask

    // k alternating pulses starting negative, gap silent cycles between them,
    // one bit per pulse, last bit fixed for even parity.
    task automatic build_valid(input int k, input int gap);
        int m = 0;
        bit par = 0;
        clear_frame();
        for (int p = 0; p < k; p++) begin
            ap[m] = 1; apos[m] = (p % 2 == 1); ab[m] = 1;
            av[m] = (p == k - 1) ? par : bit'($urandom % 2);
            par ^= av[m];
            m++;
            if (p != k - 1) m += gap;
        end
        nlen = m;
    endtask

    // Expected result computed from the requirements.
    task automatic model(input bit pre, output logic [5:0] e,
                         output logic [DW-1:0] d, output int nb);
        bit seen = 0, last = 0, par = 0;
        int cnt = 0;
        logic [5:0] v;
        e = pre ? 6'b100000 : 6'd0;
        d = '0; nb = 0;
        for (int i = 0; i < nlen; i++) begin
            v = '0;
            if (ap[i]) begin
                if (apz[i]) v[5] = 1;
                if (!seen && apos[i]) v[0] = 1;
                if (seen && apos[i] == last) v[1] = 1;
                seen = 1; last = apos[i]; cnt = 0;
            end else begin
                if (cnt == GAP - 1) v[2] = 1;
                else cnt++;
            end
            if (ab[i]) begin
                d = {d[DW-2:0], av[i]};
                par ^= av[i];
                if (nb < 31) nb++;
            end
            if (i == nlen - 1) begin
                if (par) v[3] = 1;
                if (!seen || !last) v[4] = 1;
            end
            if (e == 0 && v != 0) e = v & (~v + 6'd1);
        end
    endtask

    task automatic drive_idle();
        frm_start = 0; frm_end = 0; pulse_stb = 0; pulse_pos = 0;
        bit_stb = 0; bit_val = 0; pause_win = 0;
    endtask

    task automatic play(input bit pre, input string tag);
        logic [5:0] ee; logic [DW-1:0] ed; int en;
        model(pre, ee, ed, en);
        if (pre) begin
            @(negedge clk); drive_idle(); pause_win = 1; pulse_stb = 1; pulse_pos = 1;
        end
        @(negedge clk); drive_idle(); frm_start = 1;
        for (int i = 0; i < nlen; i++) begin
            @(negedge clk);
            drive_idle();
            pulse_stb = ap[i]; pulse_pos = apos[i]; bit_stb = ab[i];
            bit_val = av[i]; pause_win = apz[i]; frm_end = (i == nlen - 1);
        end
        @(negedge clk); drive_idle();
        chk(res_stb === 1'b1, {tag, " R2 strobe"}, int'(res_stb), 1);
        chk(res_err === ee, {tag, " error code"}, int'(res_err), int'(ee));
        chk(res_ok === (ee == 0), {tag, " R9 ok flag"}, int'(res_ok), int'(ee == 0));
        chk(res_data === ed, {tag, " R10 data"}, int'(res_data), int'(ed));
        chk(int'(res_nbits) == en, {tag, " R10 count"}, int'(res_nbits), en);
        @(negedge clk);
        chk(res_stb === 1'b0, {tag, " R2 single strobe"}, int'(res_stb), 0);
    endtask

    initial begin
        logic [5:0] prev;
        void'($urandom(32'h5EED1));
        drive_idle();
        repeat (3) @(negedge clk);
        chk(res_stb === 0 && res_ok === 0 && res_err === 0, "R1 reset flags",
            int'({res_stb, res_ok, res_err}), 0);
        chk(res_data === 0 && res_nbits === 0, "R1 reset data",
            int'(res_data), 0);
        rst_n = 1;
        @(negedge clk);
        chk(res_stb === 0 && res_err === 0, "R1 after reset", int'(res_err), 0);

        build_valid(14, 0); play(0, "R2 R10 valid request");
        build_valid(6, 1);  play(0, "R2 valid response");
        build_valid(6, 0); apos[0] = 1; play(0, "R3 start polarity");
        build_valid(6, 0); apos[2] ^= 1; play(0, "R4 alternation");
        build_valid(4, GAP - 1); play(0, "R5 gap just inside");
        build_valid(4, GAP); play(0, "R5 gap too long");
        build_valid(6, 0); av[0] ^= 1; play(0, "R6 parity");
        build_valid(5, 0); play(0, "R7 last negative");
        clear_frame(); nlen = 3; play(0, "R7 no pulses");
        build_valid(6, 0); play(1, "R8 pause before frame");
        build_valid(6, 0); apz[3] = 1; play(0, "R8 pause inside");
        build_valid(6, 0); apz[0] = 1; apos[0] = 1; play(0, "R9 tie start beats pause");
        build_valid(6, 0); apos[2] ^= 1; av[1] ^= 1; play(0, "R9 first error kept");
        build_valid(40, 0); play(0, "R10 count saturates");

        // R11: stray closing marker is ignored.
        prev = res_err;
        @(negedge clk); drive_idle(); frm_end = 1;
        @(negedge clk); drive_idle();
        chk(res_stb === 0, "R11 stray end no strobe", int'(res_stb), 0);
        chk(res_err === prev, "R11 stray end holds", int'(res_err), int'(prev));
        // R11: restart discards an erroneous partial frame.
        @(negedge clk); drive_idle(); frm_start = 1;
        @(negedge clk); drive_idle(); pulse_stb = 1; pulse_pos = 1;
        build_valid(8, 0); play(0, "R11 restart");

        for (int t = 0; t < 300; t++) begin
            int kind;
            bit pre;
            build_valid(2 * (1 + int'($urandom % 7)), int'($urandom % 4));
            kind = int'($urandom % 8);
            pre = 0;
            case (kind)
                1: apos[$urandom % nlen] ^= 1;
                2: av[$urandom % nlen] ^= 1;
                3: apz[$urandom % nlen] = 1;
                4: build_valid(4, GAP - 1 + int'($urandom % 3));
                5: pre = 1;
                6: apos[nlen - 1] = 0;
                default: ;
            endcase
            play(pre, "R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule